// File: doc/BRIEF.md
# Addressed Three-Wire Frame Receiver

This block takes display and control data from a host controller over three wires: an enable line, a shift clock and a data line. All three are treated as slow asynchronous inputs. They are brought into the system clock domain and their edges are detected there. While the enable line is low, the block shifts an 8-bit device address. When the enable line rises, the block compares that address with its own. While the enable line is high, it shifts a 50-bit frame. The frame holds a 48-bit payload followed by two steering bits.

On the falling edge of the enable line, the frame is written into one of three banks of a 105-bit display image. This happens only if the address matched, exactly 50 bits arrived and the steering value is a legal one. The first bank also carries a small control word: a port-count code, a bias select, a blanking flag and a low-power flag. Every other frame is dropped, and no state changes. The host may leave the shift clock idling high or low between transfers.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, the display image, the port code and all three control flags are zero.
- R2: The address is taken LSB first on the rising shift-clock edges while enable is low. The last 8 bits before enable rises must equal 46h, which is wire order 0,1,1,0,0,0,1,0. A frame with any other address leaves every output unchanged.
- R3: Steering value 00 selects the first bank. The steering value is formed as {first steering bit, second steering bit}. Payload bit k (k = 0 for the first bit shifted after enable rises) goes to image bit k for k = 0 to 35. Payload bits 39 to 42 form the port code, with bit 39 as its MSB. Bit 43 is the half-bias select, bit 44 is the blank flag and bit 45 is the low-power flag.
- R4: Steering value 01 writes payload bits 0 to 35 into image bits 36 to 71. Steering value 01 leaves all other outputs unchanged.
- R5: Steering value 10 writes payload bits 0 to 32 into image bits 72 to 104. Steering value 10 leaves all other outputs unchanged.
- R6: A frame with steering value 11 leaves every output unchanged.
- R7: A frame with any bit count other than 50 while enable is high leaves every output unchanged. This covers both shorter and longer frames.
- R8: Reception gives the same result whether the shift clock idles low or high between transfers.
- R9: Outputs change only as a result of an enable falling edge. They are stable while a frame is being shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Serial enable: low for address, high for frame |
| ser_clk | input | 1 | Serial shift clock, bits taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| disp_img | output | 105 | Display image, bit i is display bit i+1 |
| port_code | output | 4 | Number of pins used as plain outputs |
| half_bias | output | 1 | 1 selects half bias, 0 selects third bias |
| seg_blank | output | 1 | 1 forces segments off |
| low_power | output | 1 | 1 selects the power-saving mode |

## Verification
On every cycle, the assertions check four things. The outputs move only in the cycle after an enable falling edge. A wrong address, a wrong bit count or steering value 11 at that edge leaves the outputs frozen. A write to the last bank leaves the lower image untouched. The bit counter stays within its saturation limit. Only the bench scenarios can show that each payload bit reaches the right image or control position. The same scenarios show that both clock idle levels decode identically and that the LSB-first address order is honoured.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter logic [7:0] DEV_ADDR = 8'h46,
  parameter int NDISP = 105,
  parameter int PLEN  = 48,
  parameter int NDIR  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_en,
  input  logic             ser_clk,
  input  logic             ser_dat,
  output logic [NDISP-1:0] disp_img,
  output logic [3:0]       port_code,
  output logic             half_bias,
  output logic             seg_blank,
  output logic             low_power
);
  localparam int FLEN = PLEN + NDIR;
  localparam int CW   = $clog2(FLEN + 2);
  localparam int BW   = 36;
  localparam int LW   = NDISP - 2 * BW;

  logic [2:0] en_q, sck_q;
  logic [1:0] dat_q;
  logic [7:0] addr_sr;
  logic       addr_ok;
  logic [CW-1:0] cnt;
  logic [FLEN-1:0] frame;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= '0;
      sck_q <= '0;
      dat_q <= '0;
    end else begin
      en_q  <= {en_q[1:0], ser_en};
      sck_q <= {sck_q[1:0], ser_clk};
      dat_q <= {dat_q[0], ser_dat};
    end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire ce_rise  = en_q[1] & ~en_q[2];
  wire ce_fall  = ~en_q[1] & en_q[2];
  wire din      = dat_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_sr <= '0;
      addr_ok <= 1'b0;
      cnt     <= '0;
      frame   <= '0;
    end else begin
      if (sck_rise && !en_q[1]) addr_sr <= {din, addr_sr[7:1]};
      if (ce_rise) begin
        addr_ok <= (addr_sr == DEV_ADDR);
        cnt     <= '0;
      end else if (sck_rise && en_q[1]) begin
        frame <= {frame[FLEN-2:0], din};
        if (cnt != CW'(FLEN + 1)) cnt <= cnt + 1'b1;
      end
    end

  wire [1:0]      dir  = frame[1:0];
  wire [PLEN-1:0] pay  = frame[FLEN-1:NDIR];
  wire            take = ce_fall && addr_ok && (cnt == CW'(FLEN)) && (dir != 2'b11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      disp_img  <= '0;
      port_code <= '0;
      half_bias <= 1'b0;
      seg_blank <= 1'b0;
      low_power <= 1'b0;
    end else if (take) begin
      case (dir)
        2'b00: begin
          for (int i = 0; i < BW; i++) disp_img[i] <= pay[PLEN-1-i];
          port_code <= {pay[PLEN-40], pay[PLEN-41], pay[PLEN-42], pay[PLEN-43]};
          half_bias <= pay[PLEN-44];
          seg_blank <= pay[PLEN-45];
          low_power <= pay[PLEN-46];
        end
        2'b01: for (int i = 0; i < BW; i++) disp_img[BW+i] <= pay[PLEN-1-i];
        default: for (int i = 0; i < LW; i++) disp_img[2*BW+i] <= pay[PLEN-1-i];
      endcase
    end

  wire [NDISP+6:0] outs = {disp_img, port_code, half_bias, seg_blank, low_power};

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> $stable(outs));
  assert_bad_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && !addr_ok) |=> $stable(outs));
  assert_bad_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && dir == 2'b11) |=> $stable(outs));
  assert_bad_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && cnt != CW'(FLEN)) |=> $stable(outs));
  assert_last_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && dir == 2'b10) |=> $stable(disp_img[2*BW-1:0]));
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FLEN + 1));
endmodule

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb;
  logic clk = 0, rst_n = 0, ser_en = 0, ser_clk = 0, ser_dat = 0;
  logic [104:0] disp_img;
  logic [3:0] port_code;
  logic half_bias, seg_blank, low_power;
  always #4 clk = ~clk;

  serial_frame_rx u_dut (.clk, .rst_n, .ser_en, .ser_clk, .ser_dat,
    .disp_img, .port_code, .half_bias, .seg_blank, .low_power);

  typedef struct { logic [104:0] img; logic [3:0] pc; logic dr, sc, bu; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic [104:0] m_img = '0;
  logic [3:0] m_pc = '0;
  logic m_dr = 0, m_sc = 0, m_bu = 0;

  task automatic chk(string tag, string what, logic [104:0] act, logic [104:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag, logic [104:0] img, logic [3:0] pc, logic dr, logic sc, logic bu);
    chk(tag, "image", disp_img, img);
    chk(tag, "port_code", 105'(port_code), 105'(pc));
    chk(tag, "half_bias", 105'(half_bias), 105'(dr));
    chk(tag, "seg_blank", 105'(seg_blank), 105'(sc));
    chk(tag, "low_power", 105'(low_power), 105'(bu));
  endtask

  task automatic push(string tag);
    item_t it;
    it.img = m_img; it.pc = m_pc; it.dr = m_dr; it.sc = m_sc; it.bu = m_bu; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic sbit(logic b, bit hi);
    if (hi) begin
      ser_clk = 0; ser_dat = b;
      repeat (4) @(negedge clk); ser_clk = 1;
      repeat (4) @(negedge clk);
    end else begin
      ser_dat = b;
      repeat (4) @(negedge clk); ser_clk = 1;
      repeat (4) @(negedge clk); ser_clk = 0;
    end
  endtask

  task automatic frame(logic [7:0] adr, logic [47:0] pay, logic [1:0] dir,
                       int nbits, bit hi, bit ok, string tag);
    logic [49:0] bits = {pay, dir};
    ser_clk = hi; ser_en = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) sbit(adr[i], hi);
    repeat (4) @(negedge clk); ser_en = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) sbit(i < 50 ? bits[49-i] : 1'b0, hi);
    cmp_all({tag, "/R9 mid-frame"}, m_img, m_pc, m_dr, m_sc, m_bu);
    repeat (4) @(negedge clk); ser_en = 0;
    if (ok) begin
      case (dir)
        2'b00: begin
          for (int i = 0; i < 36; i++) m_img[i] = bits[49-i];
          m_pc = {bits[49-39], bits[49-40], bits[49-41], bits[49-42]};
          m_dr = bits[49-43]; m_sc = bits[49-44]; m_bu = bits[49-45];
        end
        2'b01: for (int i = 0; i < 36; i++) m_img[36+i] = bits[49-i];
        default: for (int i = 0; i < 33; i++) m_img[72+i] = bits[49-i];
      endcase
    end
    push(tag);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    forever begin
      item_t it;
      wait (q.size() > 0);
      repeat (8) @(negedge clk);
      it = q.pop_front();
      cmp_all(it.tag, it.img, it.pc, it.dr, it.sc, it.bu);
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    push("R1 reset");
    repeat (12) @(negedge clk);
    frame(8'h46, 48'hA5C3_1E7B_9D2C, 2'b00, 50, 0, 1, "R3 bank0 idle-low");
    frame(8'h46, 48'h3C96_F0A5_5A70, 2'b01, 50, 1, 1, "R4/R8 bank1 idle-high");
    frame(8'h46, 48'hDEAD_BEEF_1234, 2'b10, 50, 0, 1, "R5 bank2");
    frame(8'h62, 48'hFFFF_FFFF_FFFF, 2'b00, 50, 0, 0, "R2 wrong address");
    frame(8'h46, 48'h0123_4567_89AB, 2'b11, 50, 1, 0, "R6 steering 11");
    frame(8'h46, 48'hFFFF_FFFF_FFFF, 2'b01, 49, 0, 0, "R7 short frame");
    frame(8'h46, 48'hFFFF_FFFF_FFFF, 2'b10, 51, 1, 0, "R7 long frame");
    frame(8'h46, 48'h5A5A_5A5A_4A94, 2'b00, 50, 1, 1, "R8/R3 bank0 idle-high");
    frame(8'h46, 48'h0000_0000_0000, 2'b10, 50, 1, 1, "R5/R8 bank2 clear");
    wait (q.size() == 0);
    repeat (20) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule